// File: doc/BRIEF.md
# SD card clock control unit

This block derives the clock for an SD/MMC-style card bus from a faster adapter clock. In divider mode it produces a clock with equal high and low phases whose length is set by a programmable divider value. In bypass mode the adapter clock itself is forwarded to the card. The block is powered on and off through a control input. Software writes the control fields into a register elsewhere, and this block sees them as plain inputs.

On top of frequency generation, the clock can be gated in four ways. The block powers down when power is off. The card clock is switched off when its enable is 0. With power-save on, the clock pauses while the bus reports idle. With hardware flow control on, the clock stalls while the FIFO is nearly empty or nearly full. Every stop and restart happens on the low level, so no phase is ever cut short. The block also presents a one-cycle strobe for each rising and each falling card clock edge that really occurs, for use by the command and data shift logic. The configured bus width (1, 4 or 8 lines, one line after reset) is a separate setting and has no influence on this block.

Top module: `sdclk_ctrl`

## Requirements
- R1: In divider mode with the clock running, each high phase and each low phase lasts (div_val+1) adapter cycles, so the card clock period is 2*(div_val+1) adapter cycles.
- R2: In bypass mode with the clock running, the card clock follows the adapter clock: it is high during every adapter high phase, and both strobes are 1 in every adapter cycle.
- R3: With ps_en_i=1 and bus_idle_i=1 no new high phase starts and the clock stays low. Once bus_idle_i returns to 0, the clock resumes.
- R4: With power_on_i=0 no card clock edges are produced after any high phase in progress has completed.
- R5: With hw_flow_en_i=1 the clock stalls low while fifo_near_empty_i=1 or fifo_near_full_i=1. With hw_flow_en_i=0 both FIFO inputs have no effect.
- R6: With clk_en_i=0 the card clock stays low whatever the other gating inputs are.
- R7: Gating never shortens a phase. A started high phase always runs its full length, and a stopped clock always rests low.
- R8: A new div_val or bypass_i is adopted only at a falling edge of the card clock, or while the clock rests low after a completed low phase.
- R9: rise_stb_o and fall_stb_o are 1 for exactly one adapter cycle following each card clock rising or falling edge that actually appears, and they stay 0 while the clock is gated.
- R10: During synchronous reset, and in the cycle after it, the card clock and both strobes are 0, bypass is off and the active divider value is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Adapter clock |
| rst_i | input | 1 | Synchronous reset, active high |
| power_on_i | input | 1 | 1 = powered on, 0 = powered off |
| clk_en_i | input | 1 | Card clock enable |
| div_val_i | input | DIV_W | Divider value; half period is div_val+1 cycles |
| bypass_i | input | 1 | 1 = forward adapter clock |
| ps_en_i | input | 1 | Power-save enable |
| hw_flow_en_i | input | 1 | Hardware flow-control enable |
| bus_idle_i | input | 1 | No command or data transfer pending |
| fifo_near_empty_i | input | 1 | FIFO cannot supply data |
| fifo_near_full_i | input | 1 | FIFO cannot accept data |
| card_clk_o | output | 1 | Card clock |
| rise_stb_o | output | 1 | One-cycle strobe after a card clock rising edge |
| fall_stb_o | output | 1 | One-cycle strobe after a card clock falling edge |

## Verification
The bench builds the block with its defaults: an 8-bit divider value and the bypass path generated. It drives divider values of 0, 1 and 3, which exercises the shortest half period, where wait-at-terminal and load decisions share one cycle. Longer divider values are not needed, because the counter compare does not depend on the width. Because the bypass variant is present, the bench can check transitions between divided and forwarded clocks in both directions, with the negative-edge gate included. Random gating input patterns are also applied, with a clock-by-clock model that checks both clock levels and both strobes.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
   // Smallest and largest supported divider widths
   localparam int unsigned DIV_W_MIN = 1;
   localparam int unsigned DIV_W_MAX = 16;

   typedef enum logic [1:0] {
      PH_LOW_COUNT = 2'd0,
      PH_LOW_WAIT  = 2'd1,
      PH_HIGH      = 2'd2
   } sdclk_phase_e;
endpackage

// File: rtl/sdclk_gate_cond.sv
module sdclk_gate_cond (
   input  logic power_on_i,
   input  logic clk_en_i,
   input  logic ps_en_i,
   input  logic hw_flow_en_i,
   input  logic bus_idle_i,
   input  logic fifo_near_empty_i,
   input  logic fifo_near_full_i,
   output logic pass_o
);
   logic idle_hold;
   logic flow_hold;

   always_comb begin
      idle_hold = ps_en_i & bus_idle_i;
      flow_hold = hw_flow_en_i & (fifo_near_empty_i | fifo_near_full_i);
      pass_o    = power_on_i & clk_en_i & ~idle_hold & ~flow_hold;
   end
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
   import sdclk_pkg::*;
#(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             pass_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             byp_i,
   output logic             clk_q_o,
   output logic             byp_act_o,
   output logic             rise_o,
   output logic             fall_o
);
   logic [DIV_W-1:0] cnt_q, cnt_n;
   logic [DIV_W-1:0] div_act_q;
   logic             byp_act_q;
   logic             clk_q, clk_n;
   logic             load;
   logic             term;
   logic             rise_q, fall_q;
   sdclk_phase_e     phase;

   always_comb begin
      term = (cnt_q >= div_act_q);
      if (clk_q)      phase = PH_HIGH;
      else if (!term) phase = PH_LOW_COUNT;
      else            phase = PH_LOW_WAIT;
   end

   always_comb begin
      clk_n = clk_q;
      cnt_n = cnt_q;
      load  = 1'b0;
      if (byp_act_q) begin
         clk_n = 1'b0;
         cnt_n = '0;
         load  = 1'b1;
      end else begin
         unique case (phase)
            PH_HIGH: begin
               if (term) begin
                  clk_n = 1'b0;
                  cnt_n = '0;
                  load  = 1'b1;
               end else begin
                  cnt_n = cnt_q + 1'b1;
               end
            end
            PH_LOW_COUNT: cnt_n = cnt_q + 1'b1;
            default: begin
               if (pass_i) begin
                  clk_n = 1'b1;
                  cnt_n = '0;
               end else begin
                  load = 1'b1;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         clk_q     <= 1'b0;
         cnt_q     <= '0;
         div_act_q <= '0;
         byp_act_q <= 1'b0;
         rise_q    <= 1'b0;
         fall_q    <= 1'b0;
      end else begin
         clk_q  <= clk_n;
         cnt_q  <= cnt_n;
         rise_q <= clk_n & ~clk_q;
         fall_q <= ~clk_n & clk_q;
         if (load) begin
            div_act_q <= div_i;
            byp_act_q <= byp_i;
         end
      end
   end

   assign clk_q_o   = clk_q;
   assign byp_act_o = byp_act_q;
   assign rise_o    = rise_q;
   assign fall_o    = fall_q;

   // R7: a high phase is never cut short
   p_high_len_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (clk_q && (cnt_q < div_act_q)) |=> clk_q);
   // R3, R5, R6: a blocked clock resting low does not rise
   p_gated_low_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (!clk_q && !pass_i) |=> !clk_q);
   // R8: configuration is frozen throughout a high phase
   p_cfg_frozen_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      clk_q |-> ($stable(div_act_q) && $stable(byp_act_q)));
   // R9: a rise strobe only accompanies a high clock
   p_rise_match_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      rise_q |-> clk_q);
   p_fall_match_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      fall_q |-> !clk_q);
endmodule

// File: rtl/sdclk_bypass_gate.sv
module sdclk_bypass_gate (
   input  logic clk_i,
   input  logic rst_i,
   input  logic pass_i,
   input  logic byp_act_i,
   output logic card_pulse_o,
   output logic stb_o
);
   logic gate_q;
   logic stb_q;

   // Enable captured while the adapter clock is low, so it changes only then
   always_ff @(negedge clk_i) begin
      if (rst_i) gate_q <= 1'b0;
      else       gate_q <= pass_i & byp_act_i;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) stb_q <= 1'b0;
      else       stb_q <= gate_q;
   end

   assign card_pulse_o = clk_i & gate_q;
   assign stb_o        = stb_q;

   // R9: no forwarded-clock strobe outside bypass mode
   p_stb_mode_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      !byp_act_i |=> !stb_q);
endmodule

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
   import sdclk_pkg::*;
#(
   parameter int unsigned DIV_W     = 8,
   parameter bit          BYPASS_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             power_on_i,
   input  logic             clk_en_i,
   input  logic [DIV_W-1:0] div_val_i,
   input  logic             bypass_i,
   input  logic             ps_en_i,
   input  logic             hw_flow_en_i,
   input  logic             bus_idle_i,
   input  logic             fifo_near_empty_i,
   input  logic             fifo_near_full_i,
   output logic             card_clk_o,
   output logic             rise_stb_o,
   output logic             fall_stb_o
);
   if (DIV_W < DIV_W_MIN || DIV_W > DIV_W_MAX) begin : g_bad_width
      $error("sdclk_ctrl: DIV_W out of supported range");
   end

   logic pass;
   logic byp_req;
   logic clk_q;
   logic byp_act;
   logic div_rise, div_fall;
   logic byp_pulse, byp_stb;

   sdclk_gate_cond i_gate_cond (
      .power_on_i        (power_on_i),
      .clk_en_i          (clk_en_i),
      .ps_en_i           (ps_en_i),
      .hw_flow_en_i      (hw_flow_en_i),
      .bus_idle_i        (bus_idle_i),
      .fifo_near_empty_i (fifo_near_empty_i),
      .fifo_near_full_i  (fifo_near_full_i),
      .pass_o            (pass)
   );

   sdclk_divider #(.DIV_W(DIV_W)) i_divider (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .pass_i    (pass),
      .div_i     (div_val_i),
      .byp_i     (byp_req),
      .clk_q_o   (clk_q),
      .byp_act_o (byp_act),
      .rise_o    (div_rise),
      .fall_o    (div_fall)
   );

   if (BYPASS_EN) begin : g_bypass
      assign byp_req = bypass_i;
      sdclk_bypass_gate i_bypass_gate (
         .clk_i        (clk_i),
         .rst_i        (rst_i),
         .pass_i       (pass),
         .byp_act_i    (byp_act),
         .card_pulse_o (byp_pulse),
         .stb_o        (byp_stb)
      );
   end else begin : g_no_bypass
      assign byp_req   = 1'b0;
      assign byp_pulse = 1'b0;
      assign byp_stb   = 1'b0;
   end

   assign card_clk_o = clk_q | byp_pulse;
   assign rise_stb_o = div_rise | byp_stb;
   assign fall_stb_o = div_fall | byp_stb;

   // R4: while powered off, a resting low clock stays low
   p_off_low_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      (!power_on_i && !clk_q) |=> !clk_q);
   // R6: clock enable low keeps a resting clock low
   p_cen_low_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (!clk_en_i && !clk_q) |=> !clk_q);
   // R2: divided clock is silent while forwarding
   p_byp_quiet_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      byp_act |-> !clk_q);
   // R10: reset leaves the clock low
   p_reset_low_r10: assert property (@(posedge clk_i)
      rst_i |=> (!clk_q && !byp_act));
endmodule

// File: tb/test_sdclk_ctrl.sv
module test_sdclk_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int QTR        = 2;
   localparam int DIV_W      = 8;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             pwr = 1'b0, cen = 1'b0, byp = 1'b0, ps = 1'b0, hw = 1'b0;
   logic             idle = 1'b0, ae = 1'b0, af = 1'b0;
   logic [DIV_W-1:0] div = '0;
   logic             card_clk, rise_stb, fall_stb;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdclk_ctrl #(.DIV_W(DIV_W), .BYPASS_EN(1'b1)) i_sdclk_ctrl (
      .clk_i(clk), .rst_i(rst), .power_on_i(pwr), .clk_en_i(cen),
      .div_val_i(div), .bypass_i(byp), .ps_en_i(ps), .hw_flow_en_i(hw),
      .bus_idle_i(idle), .fifo_near_empty_i(ae), .fifo_near_full_i(af),
      .card_clk_o(card_clk), .rise_stb_o(rise_stb), .fall_stb_o(fall_stb)
   );

   // Behavioural reference state
   bit m_hi, m_byp, m_gate, m_stb, m_rise, m_fall;
   int m_cnt, m_div;

   function automatic bit run_ok();
      return pwr && cen && !(ps && idle) && !(hw && (ae || af));
   endfunction

   function automatic string tag_of();
      if (rst || $time < CLK_PERIOD * 2) return "R10";
      if (!pwr) return "R4";
      if (!cen) return "R6";
      if (m_byp) return "R2";
      return "R1";
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
      end
   endtask

   task automatic check_int(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   // Model advance on adapter rising edge, then compare both levels
   always begin
      @(posedge clk);
      if (rst) begin
         m_hi = 0; m_cnt = 0; m_div = 0; m_byp = 0;
         m_rise = 0; m_fall = 0; m_stb = 0;
      end else begin
         bit go;
         go = run_ok();
         m_stb = m_gate;
         m_rise = 0; m_fall = 0;
         if (m_byp) begin
            m_div = int'(div); m_byp = byp; m_hi = 0; m_cnt = 0;
         end else if (m_hi) begin
            if (m_cnt >= m_div) begin
               m_hi = 0; m_cnt = 0; m_fall = 1;
               m_div = int'(div); m_byp = byp;
            end else m_cnt++;
         end else if (m_cnt < m_div) begin
            m_cnt++;
         end else if (go) begin
            m_hi = 1; m_cnt = 0; m_rise = 1;
         end else begin
            m_div = int'(div); m_byp = byp;
         end
      end
      #(QTR);
      check(tag_of(), card_clk, m_hi | m_gate);
      check("R9", rise_stb, m_rise | m_stb);
      check("R9", fall_stb, m_fall | m_stb);
      @(negedge clk);
      m_gate = rst ? 1'b0 : (run_ok() && m_byp);
      #(QTR);
      check((m_hi || !m_byp) ? "R7" : "R2", card_clk, m_hi);
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic count_rise(input int n, output int cnt);
      cnt = 0;
      repeat (n) begin
         @(posedge clk);
         #(QTR);
         if (rise_stb) cnt++;
      end
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n;
      step(4);
      check("R10", card_clk, 1'b0);
      check("R10", rise_stb, 1'b0);
      rst = 0;
      step(1);
      check("R10", card_clk, 1'b0);
      // R1: divider 3 gives period 8
      pwr = 1; cen = 1; div = 8'd3;
      step(20);
      count_rise(32, n);
      check_int("R1", n, 4);
      // R1: divider 0 gives period 2
      div = 8'd0;
      step(20);
      count_rise(20, n);
      check_int("R1", n, 10);
      // R8: change while running, model tracks adoption point
      div = 8'd1;
      step(13);
      count_rise(20, n);
      check_int("R8", n, 5);
      // R2: forwarded clock, one rise strobe every cycle
      byp = 1;
      step(10);
      count_rise(10, n);
      check_int("R2", n, 10);
      byp = 0;
      step(12);
      // R3: power-save idle stops the clock, resumes after
      ps = 1; idle = 1;
      step(10);
      count_rise(20, n);
      check_int("R3", n, 0);
      idle = 0;
      step(6);
      count_rise(20, n);
      check_int("R3", n, 5);
      ps = 0;
      // R5: flow control stall, and no effect when disabled
      hw = 1; ae = 1;
      step(10);
      count_rise(20, n);
      check_int("R5", n, 0);
      ae = 0; af = 1;
      step(4);
      count_rise(20, n);
      check_int("R5", n, 0);
      hw = 0;
      step(6);
      count_rise(20, n);
      check_int("R5", n, 5);
      af = 0;
      // R6: clock enable low overrides everything, bypass included
      cen = 0; byp = 1;
      step(10);
      count_rise(20, n);
      check_int("R6", n, 0);
      cen = 1;
      step(6);
      count_rise(10, n);
      check_int("R2", n, 10);
      // R4: power off in bypass and divider modes
      pwr = 0;
      step(4);
      count_rise(10, n);
      check_int("R4", n, 0);
      byp = 0; pwr = 1;
      step(8);
      pwr = 0;
      step(6);
      count_rise(20, n);
      check_int("R4", n, 0);
      pwr = 1;
      // R7, R8, R9: random gating and configuration traffic against the model
      for (int i = 0; i < 3000; i++) begin
         @(posedge clk);
         #1;
         idle = ($urandom_range(0, 3) == 0);
         ae   = ($urandom_range(0, 5) == 0);
         af   = ($urandom_range(0, 7) == 0);
         ps   = ($urandom_range(0, 1) == 1);
         hw   = ($urandom_range(0, 1) == 1);
         if ($urandom_range(0, 40) == 0) div = 8'($urandom_range(0, 3));
         if ($urandom_range(0, 60) == 0) byp = ~byp;
         if ($urandom_range(0, 80) == 0) cen = ~cen;
         if ($urandom_range(0, 100) == 0) pwr = ~pwr;
      end
      // R10: reset mid-run
      rst = 1;
      step(2);
      check("R10", card_clk, 1'b0);
      check("R10", fall_stb, 1'b0);
      rst = 0;
      step(3);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule